// File: doc/BRIEF.md
# Multi-Thread Synchronous Slave FIFO Port

This block is the device side of a synchronous FIFO port that an external master drives on the interface clock. Behind the port sit four independent thread buffers. Each sampled write strobe pushes the bus word into the selected thread. Each sampled read strobe pops the head of the selected thread. The thread is chosen either by a 2-bit address on every cycle or, in a fixed build, by a thread number set at elaboration. All strobes, chip select and output enable are active low.

Words written into a thread are also counted into a pending packet for that thread. When the master raises packet end, or when the pending packet reaches a configured maximum length, the port reports a packet commit on a downstream sink: a one-cycle valid with the thread number and the length in words. A packet-end strobe with no write commits whatever is pending, and that count is zero for a zero-length packet. Two registered status outputs each report one chosen condition (empty, full, or occupancy at or above a watermark) for either a fixed thread or the addressed thread.

The data width is a parameter (8, 16 or 32 bits). A byte-order parameter reverses the byte lanes of the bus word on its way into storage. The read path always presents words in storage order.

Top module: `slave_fifo_port`

## Requirements
- R1: After reset every thread is empty with no pending packet, `pkt_valid` is 0 and both status outputs are 0 (default build: status A shows full, status B shows occupancy at or above the watermark).
- R2: With `DYN_ADDR`=1 the thread used by strobes, packet end and read data is `addr`. With `DYN_ADDR`=0 it is `FIXED_THREAD` whatever `addr` holds. `pkt_thread` reports that thread.
- R3: With `cs_n` low and `wr_n` low at a rising edge, the bus word is stored at the tail of the selected thread. A write to a thread that holds `DEPTH` words at that edge is dropped and leaves the thread unchanged.
- R4: `data_out` is registered and, after each edge, holds the head word of the thread selected in the cycle before that edge. With `cs_n` and `rd_n` low, the head is popped first. A read from an empty thread is dropped. A read and a write in the same cycle on a thread that is neither empty nor full leave its occupancy unchanged.
- R5: `data_drive` is 1 exactly while `cs_n` and `oe_n` are both low.
- R6: While `cs_n` is high, the read, write and packet-end strobes have no effect on any thread and produce no commit.
- R7: Packet end sampled together with an accepted write commits the pending words plus that word, and the pending count restarts at 0.
- R8: Packet end sampled with no accepted write commits the pending count. That count is 0 for a zero-length packet.
- R9: An accepted write that brings the pending count to `MAX_PKT` commits automatically. If packet end arrives on that same word, only one commit occurs. `pkt_len` never exceeds `MAX_PKT`.
- R10: Status outputs are registered. Each reflects the occupancies held before the edge that loads it, and a dynamic status uses the thread selected in the cycle before that edge.
- R11: With `BIG_ENDIAN`=1 the byte lanes of a written word are reversed in storage, so byte 0 of the stored word is the most significant bus byte. A word read back therefore appears byte-reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| pktend_n | input | 1 | Packet end, active low |
| addr | input | 2 | Thread address |
| data_in | input | DATA_W | Write data from the master |
| data_out | output | DATA_W | Registered head word of the addressed thread |
| data_drive | output | 1 | Bus driver enable for `data_out` |
| stat_a | output | 1 | Status output A |
| stat_b | output | 1 | Status output B |
| pkt_valid | output | 1 | One-cycle packet commit strobe |
| pkt_thread | output | 2 | Thread of the committed packet |
| pkt_len | output | $clog2(MAX_PKT+1) | Committed length in words, 0 for a zero-length packet |

## Verification
Two pairs of events can land in the same cycle. The first is a read and a write on one thread. The second is a packet-end strobe on the word that also reaches the maximum packet length. Directed sequences force both: a one-word thread that is popped and pushed in the same cycle must present the new word as its head, and a packet-end on the sixth word must give exactly one commit of length six. Random traffic adds many more overlaps of both kinds, including reads and writes on a full or empty thread. A second instance, built big-endian with a fixed thread, runs the same stimulus and is judged against a bench model of the pointers, occupancies and pending counts.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    // Condition that a status output reports about its tracked thread
    typedef enum logic [1:0] {
        FLAG_EMPTY   = 2'd0,
        FLAG_FULL    = 2'd1,
        FLAG_PARTIAL = 2'd2
    } sfp_flag_kind_e;

    localparam int unsigned SFP_THREADS = 4;
    localparam int unsigned SFP_TW      = 2;

endpackage

// File: rtl/sfp_lane_order.sv
module sfp_lane_order #(
    parameter int unsigned DATA_W  = 16,
    parameter bit          REVERSE = 1'b0
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned NB = DATA_W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        if (REVERSE) begin : g_rev
            assign dout[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
        end else begin : g_keep
            assign dout[b*8 +: 8] = din[b*8 +: 8];
        end
    end
endmodule

// File: rtl/sfp_thread_mem.sv
module sfp_thread_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORDS  = 32
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [$clog2(WORDS)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(WORDS)-1:0]  rd_addr,
    output logic [DATA_W-1:0]         rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sfp_status.sv
module sfp_status
    import sfp_pkg::*;
#(
    parameter int unsigned     DEPTH     = 8,
    parameter int unsigned     WATERMARK = 5,
    parameter sfp_flag_kind_e  KIND      = FLAG_FULL,
    parameter bit              DYNAMIC   = 1'b0,
    parameter int unsigned     THREAD    = 0,
    localparam int unsigned    CW        = $clog2(DEPTH + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [SFP_THREADS-1:0][CW-1:0]       occ,
    input  logic [SFP_TW-1:0]                    cur_thr,
    output logic                                 flag
);
    logic [SFP_TW-1:0] trk_thr;
    logic [CW-1:0]     trk_occ;
    logic              flag_d, flag_q;

    always_comb begin
        trk_thr = DYNAMIC ? cur_thr : SFP_TW'(THREAD);
        trk_occ = occ[trk_thr];
        case (KIND)
            FLAG_EMPTY:   flag_d = (trk_occ == '0);
            FLAG_FULL:    flag_d = (trk_occ == CW'(DEPTH));
            FLAG_PARTIAL: flag_d = (trk_occ >= CW'(WATERMARK));
            default:      flag_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R10: a fixed-thread empty indicator can never be set while that thread holds words
    assert_flag_sane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == FLAG_EMPTY && !DYNAMIC && flag_q) |-> ($past(occ[THREAD]) == '0));
endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port
    import sfp_pkg::*;
#(
    parameter int unsigned    DATA_W       = 16,
    parameter int unsigned    DEPTH        = 8,
    parameter int unsigned    MAX_PKT      = 6,
    parameter int unsigned    WATERMARK    = 5,
    parameter bit             DYN_ADDR     = 1'b1,
    parameter int unsigned    FIXED_THREAD = 0,
    parameter bit             BIG_ENDIAN   = 1'b0,
    parameter sfp_flag_kind_e FLAGA_KIND   = FLAG_FULL,
    parameter bit             FLAGA_DYN    = 1'b1,
    parameter int unsigned    FLAGA_THREAD = 0,
    parameter sfp_flag_kind_e FLAGB_KIND   = FLAG_PARTIAL,
    parameter bit             FLAGB_DYN    = 1'b0,
    parameter int unsigned    FLAGB_THREAD = 2,
    localparam int unsigned   LW           = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic              pktend_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_drive,
    output logic              stat_a,
    output logic              stat_b,
    output logic              pkt_valid,
    output logic [1:0]        pkt_thread,
    output logic [LW-1:0]     pkt_len
);
    localparam int unsigned T  = SFP_THREADS;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned MW = SFP_TW + PW;

    typedef struct packed {
        logic [T-1:0][CW-1:0] cnt;
        logic [T-1:0][PW-1:0] rp;
        logic [T-1:0][PW-1:0] wp;
        logic [T-1:0][LW-1:0] pend;
        logic [DATA_W-1:0]    dout;
        logic                 pv;
        logic [SFP_TW-1:0]    pthr;
        logic [LW-1:0]        plen;
    } port_state_t;

    port_state_t st_d, st_q;

    // ---------------- front-end decode ----------------
    logic [SFP_TW-1:0] sel;
    logic              wr_ok, rd_ok, pe_hit;
    logic [PW-1:0]     head_ptr;
    logic [DATA_W-1:0] wdata_st, rdata;

    always_comb begin
        sel      = DYN_ADDR ? addr : SFP_TW'(FIXED_THREAD);
        wr_ok    = !cs_n && !wr_n && (st_q.cnt[sel] != CW'(DEPTH));
        rd_ok    = !cs_n && !rd_n && (st_q.cnt[sel] != '0);
        pe_hit   = !cs_n && !pktend_n;
        head_ptr = st_q.rp[sel] + PW'(rd_ok);
    end

    sfp_lane_order #(
        .DATA_W  (DATA_W),
        .REVERSE (BIG_ENDIAN)
    ) u_lane (
        .din  (data_in),
        .dout (wdata_st)
    );

    sfp_thread_mem #(
        .DATA_W (DATA_W),
        .WORDS  (T * DEPTH)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr ({sel, st_q.wp[sel]}),
        .wr_data (wdata_st),
        .rd_addr ({sel, head_ptr}),
        .rd_data (rdata)
    );

    // ---------------- next state ----------------
    logic [LW-1:0] plen_n;
    logic          commit;

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        plen_n  = st_q.pend[sel] + LW'(wr_ok);
        commit  = pe_hit || (wr_ok && (plen_n == LW'(MAX_PKT)));

        if (wr_ok) st_d.wp[sel] = st_q.wp[sel] + PW'(1);
        if (rd_ok) st_d.rp[sel] = head_ptr;
        st_d.cnt[sel] = st_q.cnt[sel] + CW'(wr_ok) - CW'(rd_ok);

        if (!cs_n) begin
            if (commit) begin
                st_d.pv        = 1'b1;
                st_d.pthr      = sel;
                st_d.plen      = plen_n;
                st_d.pend[sel] = '0;
            end else begin
                st_d.pend[sel] = plen_n;
            end
        end

        // head word seen after this edge; a word written into the head slot bypasses storage
        if (wr_ok && (st_q.wp[sel] == head_ptr)) st_d.dout = wdata_st;
        else                                     st_d.dout = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- status outputs ----------------
    sfp_status #(
        .DEPTH (DEPTH), .WATERMARK (WATERMARK), .KIND (FLAGA_KIND),
        .DYNAMIC (FLAGA_DYN), .THREAD (FLAGA_THREAD)
    ) u_stat_a (
        .clk (clk), .rst_n (rst_n), .occ (st_q.cnt), .cur_thr (sel), .flag (stat_a)
    );

    sfp_status #(
        .DEPTH (DEPTH), .WATERMARK (WATERMARK), .KIND (FLAGB_KIND),
        .DYNAMIC (FLAGB_DYN), .THREAD (FLAGB_THREAD)
    ) u_stat_b (
        .clk (clk), .rst_n (rst_n), .occ (st_q.cnt), .cur_thr (sel), .flag (stat_b)
    );

    assign data_out   = st_q.dout;
    assign data_drive = !cs_n && !oe_n;
    assign pkt_valid  = st_q.pv;
    assign pkt_thread = st_q.pthr;
    assign pkt_len    = st_q.plen;

    // ---------------- assertions ----------------
    for (genvar t = 0; t < T; t++) begin : g_chk
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[t] <= CW'(DEPTH));
        assert_rdwr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !rd_n && !wr_n && sel == SFP_TW'(t) &&
             st_q.cnt[t] != '0 && st_q.cnt[t] != CW'(DEPTH)) |=> $stable(st_q.cnt[t]));
    end

    assert_cs_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(st_q.cnt) && !pkt_valid));

    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_len == '0) |-> $past(!pktend_n && !cs_n));

    assert_len_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len <= LW'(MAX_PKT)));
endmodule

// File: tb/slave_fifo_port_bench.sv
module slave_fifo_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int MAXP  = 6;
    localparam int WM    = 5;
    localparam int LW    = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1, pktend_n = 1'b1;
    logic [1:0]    addr = '0;
    logic [DW-1:0] data_in = '0;

    logic [DW-1:0] dout0, dout1;
    logic          drv0, drv1, sa0, sa1, sb0, sb1, pv0, pv1;
    logic [1:0]    pt0, pt1;
    logic [LW-1:0] pl0, pl1;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R4";

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_fifo_port #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_PKT(MAXP), .WATERMARK(WM)) u_slave_fifo_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .oe_n(oe_n), .wr_n(wr_n),
        .pktend_n(pktend_n), .addr(addr), .data_in(data_in), .data_out(dout0),
        .data_drive(drv0), .stat_a(sa0), .stat_b(sb0), .pkt_valid(pv0),
        .pkt_thread(pt0), .pkt_len(pl0));

    slave_fifo_port #(.DATA_W(DW), .DEPTH(DEPTH), .MAX_PKT(MAXP), .WATERMARK(WM),
                      .DYN_ADDR(1'b0), .FIXED_THREAD(1), .BIG_ENDIAN(1'b1)) u_slave_fifo_port_be (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .oe_n(oe_n), .wr_n(wr_n),
        .pktend_n(pktend_n), .addr(addr), .data_in(data_in), .data_out(dout1),
        .data_drive(drv1), .stat_a(sa1), .stat_b(sb1), .pkt_valid(pv1),
        .pkt_thread(pt1), .pkt_len(pl1));

    // bench model: [instance][thread]
    int          m_cnt [2][4];
    int          m_rp  [2][4];
    int          m_wp  [2][4];
    int          m_pc  [2][4];
    logic [DW-1:0] m_mem [2][4][DEPTH];

    function automatic logic [DW-1:0] swap16(input logic [DW-1:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // one interface cycle: drive, advance model, sample after the edge
    task automatic step(input bit cs, input bit rd, input bit oe, input bit wr,
                        input bit pe, input logic [1:0] a, input logic [DW-1:0] d);
        bit     e_pv [2];
        int     e_len [2], e_thr [2], e_sa [2], e_sb [2];
        bit     e_dv [2];
        logic [DW-1:0] e_d [2];
        string  ptag [2];
        @(negedge clk);
        cs_n = ~cs; rd_n = ~rd; oe_n = ~oe; wr_n = ~wr; pktend_n = ~pe; addr = a; data_in = d;
        for (int i = 0; i < 2; i++) begin
            int sel = (i == 1) ? 1 : int'(a);
            bit wok, rok, commit;
            int plen;
            e_sa[i] = (m_cnt[i][sel] == DEPTH);
            e_sb[i] = (m_cnt[i][2] >= WM);
            e_pv[i] = 1'b0; e_len[i] = 0; e_thr[i] = sel;
            ptag[i] = cs ? "R9" : "R6";
            if (cs) begin
                wok = wr && (m_cnt[i][sel] < DEPTH);
                rok = rd && (m_cnt[i][sel] > 0);
                if (wok) begin
                    m_mem[i][sel][m_wp[i][sel]] = (i == 1) ? swap16(d) : d;
                    m_wp[i][sel] = (m_wp[i][sel] + 1) % DEPTH;
                end
                if (rok) m_rp[i][sel] = (m_rp[i][sel] + 1) % DEPTH;
                m_cnt[i][sel] += int'(wok) - int'(rok);
                plen   = m_pc[i][sel] + int'(wok);
                commit = pe || (wok && plen == MAXP);
                if (commit) begin
                    e_pv[i] = 1'b1; e_len[i] = plen; m_pc[i][sel] = 0;
                    ptag[i] = pe ? (wok ? "R7" : "R8") : "R9";
                end else begin
                    m_pc[i][sel] = plen;
                end
            end
            e_dv[i] = (m_cnt[i][sel] > 0);
            e_d[i]  = m_mem[i][sel][m_rp[i][sel]];
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            chk(ptag[i], int'(i ? pv1 : pv0), int'(e_pv[i]));
            if (e_pv[i]) begin
                chk(ptag[i], int'(i ? pl1 : pl0), e_len[i]);
                chk("R2", int'(i ? pt1 : pt0), e_thr[i]);
            end
            chk("R10", int'(i ? sa1 : sa0), e_sa[i]);
            chk("R10", int'(i ? sb1 : sb0), e_sb[i]);
            chk("R5", int'(i ? drv1 : drv0), int'(cs && oe));
            if (e_dv[i]) chk((i == 1) ? "R11" : cur_tag, int'(i ? dout1 : dout0), int'(e_d[i]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_report();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++)
            for (int t = 0; t < 4; t++) begin
                m_cnt[i][t] = 0; m_rp[i][t] = 0; m_wp[i][t] = 0; m_pc[i][t] = 0;
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk("R1", int'(pv0), 0); chk("R1", int'(sa0), 0); chk("R1", int'(sb0), 0);
        chk("R1", int'(pv1), 0); chk("R1", int'(drv0), 0);

        // R6: strobes with chip select high change nothing
        cur_tag = "R6";
        step(0, 0, 1, 1, 1, 2'd3, 16'h1111);
        step(1, 0, 0, 0, 1, 2'd3, 16'h0000);   // zero-length on thread 3 (R8)
        // R7: short packet of three words on thread 1, packet end on the third
        cur_tag = "R7";
        step(1, 0, 0, 1, 0, 2'd1, 16'hA101);
        step(1, 0, 0, 1, 0, 2'd1, 16'hA102);
        step(1, 0, 1, 1, 1, 2'd1, 16'hA103);
        // R9: automatic commit at the maximum, then packet end on the last word
        cur_tag = "R9";
        for (int k = 0; k < MAXP; k++) step(1, 0, 0, 1, 0, 2'd0, 16'hB000 + DW'(k));
        for (int k = 0; k < MAXP - 1; k++) step(1, 1, 1, 0, 0, 2'd0, 16'h0);
        step(1, 1, 1, 0, 0, 2'd0, 16'h0);
        step(1, 0, 0, 1, 0, 2'd0, 16'hB100);
        step(1, 0, 0, 1, 0, 2'd0, 16'hB101);
        step(1, 0, 0, 1, 0, 2'd0, 16'hB102);
        step(1, 0, 0, 1, 0, 2'd0, 16'hB103);
        step(1, 0, 0, 1, 0, 2'd0, 16'hB104);
        step(1, 0, 0, 1, 1, 2'd0, 16'hB105);
        // R3: overfill thread 2, extra words dropped; status B crosses the watermark (R10)
        cur_tag = "R3";
        for (int k = 0; k < DEPTH + 3; k++) step(1, 0, 0, 1, 0, 2'd2, 16'hC000 + DW'(k));
        step(1, 0, 1, 0, 0, 2'd2, 16'h0);
        // R4: drain thread 2 past empty
        cur_tag = "R4";
        for (int k = 0; k < DEPTH + 2; k++) step(1, 1, 1, 0, 0, 2'd2, 16'h0);
        // R4: single word then read and write on it together
        step(1, 0, 0, 1, 0, 2'd3, 16'hD001);
        step(1, 1, 1, 1, 0, 2'd3, 16'hD002);
        step(1, 1, 1, 1, 0, 2'd3, 16'hD003);
        step(1, 1, 1, 0, 0, 2'd3, 16'h0);

        // constrained random phases
        for (int ph = 0; ph < 10; ph++) begin
            int wb = (ph % 2 == 0) ? 80 : 25;
            int rb = (ph % 2 == 0) ? 25 : 80;
            for (int n = 0; n < 400; n++) begin
                bit cs = ($urandom % 10) != 0;
                bit rd = ($urandom % 100) < rb;
                bit wr = ($urandom % 100) < wb;
                bit oe = rd || ($urandom % 2 == 0);
                bit pe = ($urandom % 14) == 0;
                cur_tag = "R4";
                step(cs, rd, oe, wr, pe, 2'($urandom % 4), DW'($urandom));
            end
        end
        step(0, 0, 0, 0, 0, 2'd0, 16'h0);
        finish_report();
    end
endmodule